// File: doc/BRIEF.md
# I2C Receive Byte Path with Holding Stage

This block sits between an I2C bus engine and the register interface of a controller, on the receive side. The bus engine hands it one data bit at a time together with a sample strobe. A shift stage assembles these bits into a byte, most significant bit first. A completed byte moves into a one-byte holding buffer as soon as the buffer is free. While the buffer is occupied, the completed byte stays parked in the shift stage.

Software sees the buffer through two read strobes. A pop read returns the byte and frees the buffer. A peek read returns the byte and leaves it in place. A data-valid status and a data-valid interrupt flag report an occupied buffer. An underflow interrupt flag reports a pop of an empty buffer.

The bit input is treated as a stream. `bit_stb` acts as valid and `~hold_off` acts as ready. A strobe is taken only when `hold_off` is low. A strobe presented while `hold_off` is high is dropped, so the bus engine must stretch the bus clock until `hold_off` falls. The read strobes, flag clears and status outputs are plain control pins.

Top module: `i2c_rx_dbuf`

## Requirements
- R1: Bits taken on `bit_stb` fill the byte MSB first. The DATA_W-th taken strobe completes the byte. If the buffer is empty, `dv_status` is high after the clock edge that follows the edge sampling that final strobe.
- R2: When a byte enters the buffer, `dv_status` and `dv_irq` are both set.
- R3: While `rd_pop` is high and the buffer is full, `rd_data` shows the buffered byte in the same cycle. After that edge, `dv_status` and `dv_irq` are both low, unless a parked byte refills the buffer as R6 describes.
- R4: A `rd_pop` while the buffer is empty sets `uf_irq` at that edge, and `rd_data` reads as 0 in that cycle.
- R5: `rd_peek` shows the buffered byte on `rd_data` without changing `dv_status`, `dv_irq`, `uf_irq` or the byte. A peek of an empty buffer reads 0 and never sets `uf_irq`.
- R6: A completed byte waits in the shift stage while the buffer is full. After a pop frees the buffer, `dv_status` is low for one cycle, and the byte transfers at the next edge with `dv_status` and `dv_irq` set again.
- R7: `hold_off` is high exactly while the shift stage holds a completed byte and the buffer is full. Strobes seen while `hold_off` is high change nothing.
- R8: `clr_dv_irq` clears `dv_irq` without touching `dv_status`. `clr_uf_irq` clears `uf_irq`. If a set and a clear of the same flag occur in one cycle, the set wins.
- R9: After reset, `dv_status`, `dv_irq`, `uf_irq` and `hold_off` are low, and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_in | input | 1 | Serial data bit from the bus engine |
| bit_stb | input | 1 | Bit valid strobe |
| rd_pop | input | 1 | Consuming read strobe |
| rd_peek | input | 1 | Non-consuming read strobe |
| clr_dv_irq | input | 1 | Clear the data-valid interrupt flag |
| clr_uf_irq | input | 1 | Clear the underflow interrupt flag |
| rd_data | output | DATA_W | Read data, 0 when the buffer is empty or no read strobe is high |
| dv_status | output | 1 | Buffer holds an unread byte |
| dv_irq | output | 1 | Data-valid interrupt flag |
| uf_irq | output | 1 | Underflow interrupt flag |
| hold_off | output | 1 | Not-ready for bits: both stages are full |

## Verification
Single bytes with mixed bit patterns (A5, 00, FF, 81) show whether MSB-first assembly and the transfer latency are right. Two bytes sent back to back, with extra strobes while `hold_off` is high, separate a correct parking stage from one that overwrites or shifts in dropped bits. Pops and peeks on full and empty buffers, with some clears issued in the same cycle as a set, tell consuming from non-consuming reads and check set-over-clear priority.

// File: rtl/rxp_pkg.sv
package rxp_pkg;
  parameter int unsigned RXP_DEF_W = 8;

  function automatic int unsigned rxp_cnt_w(input int unsigned w);
    return $clog2(w + 1);
  endfunction
endpackage

// File: rtl/rxp_flag.sv
module rxp_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;
    else if (clr_i)  q_o <= 1'b0;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o); // R8
endmodule

// File: rtl/rxp_shifter.sv
module rxp_shifter #(
  parameter int unsigned DATA_W = rxp_pkg::RXP_DEF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_in,
  input  logic              bit_stb,
  input  logic              take_i,
  output logic              full_o,
  output logic [DATA_W-1:0] byte_o
);
  localparam int unsigned CNT_W = rxp_pkg::rxp_cnt_w(DATA_W);

  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] sh_q;
  logic              accept;

  assign full_o = (cnt_q == CNT_W'(DATA_W));
  assign accept = bit_stb && (!full_o || take_i);
  assign byte_o = sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else begin
      if (take_i)      cnt_q <= accept ? CNT_W'(1) : '0;
      else if (accept) cnt_q <= cnt_q + CNT_W'(1);
      if (accept)      sh_q  <= {sh_q[DATA_W-2:0], bit_in};
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DATA_W)); // R1
  AST_PARKED_BYTE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    full_o && !take_i |=> full_o && $stable(sh_q)); // R6
endmodule

// File: rtl/rxp_holdbuf.sv
module rxp_holdbuf #(
  parameter int unsigned DATA_W = rxp_pkg::RXP_DEF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data,
  input  logic              pop_i,
  input  logic              peek_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      data_q  <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      data_q  <= load_data;
    end else if (pop_i) begin
      valid_o <= 1'b0;
    end
  end

  assign rd_data = ((pop_i || peek_i) && valid_o) ? data_q : '0;

  AST_POP_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i && valid_o |=> !valid_o); // R3
  AST_PEEK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    peek_i && !pop_i && !load_i |=> $stable(valid_o) && $stable(data_q)); // R5
  AST_NO_LOAD_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> !load_i); // R6
endmodule

// File: rtl/i2c_rx_dbuf.sv
module i2c_rx_dbuf #(
  parameter int unsigned DATA_W = rxp_pkg::RXP_DEF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_in,
  input  logic              bit_stb,
  input  logic              rd_pop,
  input  logic              rd_peek,
  input  logic              clr_dv_irq,
  input  logic              clr_uf_irq,
  output logic [DATA_W-1:0] rd_data,
  output logic              dv_status,
  output logic              dv_irq,
  output logic              uf_irq,
  output logic              hold_off
);
  logic              sh_full;
  logic              xfer;
  logic [DATA_W-1:0] sh_byte;

  assign xfer     = sh_full && !dv_status;
  assign hold_off = sh_full && dv_status;

  rxp_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_stb(bit_stb),
    .take_i(xfer), .full_o(sh_full), .byte_o(sh_byte)
  );

  rxp_holdbuf #(.DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .load_i(xfer), .load_data(sh_byte),
    .pop_i(rd_pop), .peek_i(rd_peek), .valid_o(dv_status), .rd_data(rd_data)
  );

  rxp_flag u_dv_flag (
    .clk(clk), .rst_n(rst_n), .set_i(xfer),
    .clr_i(clr_dv_irq || (rd_pop && dv_status)), .q_o(dv_irq)
  );

  rxp_flag u_uf_flag (
    .clk(clk), .rst_n(rst_n), .set_i(rd_pop && !dv_status),
    .clr_i(clr_uf_irq), .q_o(uf_irq)
  );

  AST_HOLD_NEEDS_DV: assert property (@(posedge clk) disable iff (!rst_n)
    hold_off |-> dv_status); // R7
  AST_ENTRY_SETS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> dv_status && dv_irq); // R2
  AST_EMPTY_POP_UF: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pop && !dv_status |=> uf_irq); // R4
  AST_PEEK_NO_UF: assert property (@(posedge clk) disable iff (!rst_n)
    !uf_irq && !rd_pop |=> !uf_irq); // R5
  AST_DV_IRQ_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    dv_irq |-> dv_status); // R2
endmodule

// File: tb/test_i2c_rx_dbuf.sv
module test_i2c_rx_dbuf;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_in = 1'b0, bit_stb = 1'b0, rd_pop = 1'b0, rd_peek = 1'b0;
  logic clr_dv_irq = 1'b0, clr_uf_irq = 1'b0;
  logic [7:0] rd_data;
  logic dv_status, dv_irq, uf_irq, hold_off;
  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] sb_q[$];

  always #5 clk = ~clk;

  i2c_rx_dbuf i_i2c_rx_dbuf (
    .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_stb(bit_stb),
    .rd_pop(rd_pop), .rd_peek(rd_peek), .clr_dv_irq(clr_dv_irq),
    .clr_uf_irq(clr_uf_irq), .rd_data(rd_data), .dv_status(dv_status),
    .dv_irq(dv_irq), .uf_irq(uf_irq), .hold_off(hold_off)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); bit_in = b; bit_stb = 1'b1;
    @(negedge clk); bit_stb = 1'b0;
  endtask

  // driver: pushes the expected byte into the scoreboard
  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sb_q.push_back(b);
  endtask

  // monitor side: pops the buffer and compares with the scoreboard head
  task automatic pop_check(input string req);
    logic [7:0] exp;
    @(negedge clk); rd_pop = 1'b1; #1;
    exp = (sb_q.size() > 0) ? sb_q.pop_front() : 8'h00;
    chk(req, rd_data, exp);
    @(negedge clk); rd_pop = 1'b0; #1;
  endtask

  initial begin
    #1ms;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R9 dv", dv_status, 0); chk("R9 irq", {dv_irq, uf_irq}, 0);
    chk("R9 hold", hold_off, 0); chk("R9 data", rd_data, 0);
    rst_n = 1'b1;

    // R1 R2: one byte, checked after the transfer edge
    send_byte(8'hA5);
    @(negedge clk); #1;
    chk("R1 dv after byte", dv_status, 1); chk("R2 dv_irq", dv_irq, 1);
    // R5 peek
    rd_peek = 1'b1; #1; chk("R5 peek data", rd_data, 8'hA5);
    @(negedge clk); rd_peek = 1'b0; #1;
    chk("R5 peek keeps dv", {dv_status, dv_irq, uf_irq}, 3'b110);
    pop_check("R3 pop data");
    chk("R3 cleared", {dv_status, dv_irq}, 0);

    // R4 empty pop
    @(negedge clk); rd_pop = 1'b1; #1; chk("R4 empty data", rd_data, 0);
    @(negedge clk); rd_pop = 1'b0; #1; chk("R4 uf set", uf_irq, 1);
    clr_uf_irq = 1'b1; @(negedge clk); clr_uf_irq = 1'b0; #1;
    chk("R8 uf cleared", uf_irq, 0);
    rd_peek = 1'b1; #1; chk("R5 empty peek data", rd_data, 0);
    @(negedge clk); rd_peek = 1'b0; #1; chk("R5 empty peek no uf", uf_irq, 0);
    // R8 set wins over clear
    rd_pop = 1'b1; clr_uf_irq = 1'b1;
    @(negedge clk); rd_pop = 1'b0; clr_uf_irq = 1'b0; #1;
    chk("R8 uf set wins", uf_irq, 1);
    clr_uf_irq = 1'b1; @(negedge clk); clr_uf_irq = 1'b0;

    // R6 R7: second byte parks, extra strobes dropped
    send_byte(8'h3C);
    send_byte(8'hC3);
    @(negedge clk); #1;
    chk("R7 hold high", hold_off, 1);
    repeat (3) send_bit(1'b1);
    chk("R7 still hold", hold_off, 1);
    clr_dv_irq = 1'b1; @(negedge clk); clr_dv_irq = 1'b0; #1;
    chk("R8 dv_irq cleared", dv_irq, 0); chk("R8 dv kept", dv_status, 1);
    pop_check("R3 first of pair");
    chk("R6 gap cycle", dv_status, 0);
    @(negedge clk); #1;
    chk("R6 refill", {dv_status, dv_irq}, 2'b11);
    chk("R7 hold released", hold_off, 0);
    pop_check("R7 parked byte intact");

    // R1 more patterns
    send_byte(8'h00); @(negedge clk); pop_check("R1 pattern 00");
    send_byte(8'hFF); @(negedge clk); pop_check("R1 pattern FF");
    send_byte(8'h81); @(negedge clk); pop_check("R1 pattern 81");
    chk("R3 final empty", dv_status, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule